// File: doc/BRIEF.md
# Framed Serial Transmitter with Flow Control

This block turns parallel characters from a host into framed serial characters on one output line. The host writes a character with a one-cycle write strobe into a single holding register. The transmitter moves it into its shift register at the next character boundary. It then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two high stop bits. An external bit-rate enable pulse sets the pace, and each bit lasts exactly one period of that pulse. The transmit path therefore holds at most two characters: one in the holding register and one being shifted out.

A command port enables and disables the transmitter, resets it, and starts or stops a break. Each command completes in its own way. A disable lets the character on the line finish. A reset cuts the line back to mark in the next cycle and drops everything queued. A break holds the line low from the next character boundary onward and ignores flow control. When flow control is on, a character may start only while the clear-to-send input is high. A character that has already started always completes.

Top module: `sertx_top`

## Requirements
- R1: A character is one low start bit, then N data bits with the least significant bit first, where N = 5 + cfg_len (cfg_len 0..3 gives 5..8). Data bits above N are not sent.
- R2: cfg_par = 1 adds an even parity bit after the data bits, which makes the count of ones in data plus parity even. cfg_par = 2 adds an odd parity bit. cfg_par = 0 or 3 adds no parity bit.
- R3: The frame ends with one high stop bit when cfg_stop2 = 0 and with two high stop bits when cfg_stop2 = 1.
- R4: tx_line changes only in the cycle after a cycle with bit_tick high, so each bit lasts one bit_tick period. The only exception is the reset command (R9).
- R5: ready is high exactly when the transmitter is enabled and the holding register is empty. A write with wr_en high while ready is high is taken, and ready is low from the next cycle. A write while ready is low has no effect.
- R6: empty is high when no frame is on the line and the holding register is empty. During that time the line rests at mark (high) unless a break is active. A write that is taken clears empty in the next cycle.
- R7: When a character is waiting, its start bit follows the last stop bit of the previous frame directly, with no idle bit between them.
- R8: The disable command (cmd_op = 2) lets the frame on the line complete. After that, no new frame starts and writes are ignored until the enable command (cmd_op = 1).
- R9: The reset command (cmd_op = 3) puts the line at mark in the next cycle, even in the middle of a frame. It drops the held character, clears the break and disables the transmitter.
- R10: With cfg_flow_en = 1, a frame may start only at a bit_tick where cts is high. A frame that has already started completes even if cts falls, and the line then stays at mark until cts returns.
- R11: The break-on command (cmd_op = 4) drives the line low from the next character boundary, whatever the values of cts and the enable state.
- R12: The break-off command (cmd_op = 5) returns the line to mark for one bit period. After that, queued characters are sent as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Data length select, N = 5 + cfg_len |
| cfg_par | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| cfg_stop2 | input | 1 | Two stop bits when high |
| cfg_flow_en | input | 1 | Gate frame starts on cts |
| cts | input | 1 | Clear to send, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 enable, 2 disable, 3 reset, 4 break on, 5 break off |
| tx_line | output | 1 | Serial output, idles high |
| ready | output | 1 | Holding register can take a character |
| empty | output | 1 | Nothing queued and no frame on the line |

## Verification
The bench builds the block with its default parameters: 8 data bits at most, a shortest length of 5 and a 2-bit length select, for a 12-bit frame vector. With these values it can reach every data length, both parity senses and both stop-bit counts. It drives bit_tick every fourth cycle, so each bit spans four clocks. This leaves room to place commands, writes and cts edges in the middle of a bit, at a frame's last stop bit, and between two back-to-back frames.

// File: rtl/sertx_pkg.sv
// Shared constants for the framed serial transmitter.
// Assumes cmd_op encodings are fixed by the host-side decoder.
package sertx_pkg;
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_ENABLE  = 3'd1,
        CMD_DISABLE = 3'd2,
        CMD_RESET   = 3'd3,
        CMD_BRK_ON  = 3'd4,
        CMD_BRK_OFF = 3'd5
    } cmd_e;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/sertx_framer.sv
// Builds the full bit pattern of one character from data and configuration.
// Purely combinational. Bit 0 of the frame goes out first. Bits past the
// frame length read as one, so the stop bits come for free.
// Assumes MIN_LEN + 2**LEN_W - 1 <= DATA_W.
module sertx_framer #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int FRAME_W = 12,
    parameter int CNT_W   = 4
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [LEN_W-1:0]   len_sel,
    input  logic [1:0]         par_sel,
    input  logic               stop2,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   frame_bits
);
    import sertx_pkg::*;

    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] masked;
    logic              par_on;
    logic              par_bit;

    // Masks the data to the selected length and derives the parity bit.
    always_comb begin
        nbits  = CNT_W'(MIN_LEN) + CNT_W'(len_sel);
        masked = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) masked[i] = data[i];
        end
        par_on  = (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
        par_bit = (^masked) ^ (par_sel == PAR_ODD);
    end

    // Places the start bit, data bits and parity bit, and computes the length.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) frame[i+1] = data[i];
        end
        if (par_on) frame[nbits + CNT_W'(1)] = par_bit;
        frame_bits = CNT_W'(1) + nbits + CNT_W'(par_on) + (stop2 ? CNT_W'(2) : CNT_W'(1));
    end
endmodule

// File: rtl/sertx_cmdctl.sv
// Decodes the command strobe into the enable and break flags and a one-cycle
// soft reset. Assumes at most one command per cycle.
module sertx_cmdctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       soft_rst,
    output logic       en_q,
    output logic       brk_q
);
    import sertx_pkg::*;

    assign soft_rst = cmd_valid && (cmd_op == CMD_RESET);

    // Holds the enable and break flags. A soft reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else if (cmd_valid) begin
            case (cmd_op)
                CMD_ENABLE:  en_q  <= 1'b1;
                CMD_DISABLE: en_q  <= 1'b0;
                CMD_BRK_ON:  brk_q <= 1'b1;
                CMD_BRK_OFF: brk_q <= 1'b0;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/sertx_holdreg.sv
// One-entry holding register between the host and the shifter.
// Assumes take (shifter load) only occurs while full is high.
module sertx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ready
);
    logic accept;

    assign ready  = en && !full;
    assign accept = wr_en && ready && !soft_rst;

    // Fills on a write that is taken and drains when the shifter loads.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
// Drives the serial line. It advances one bit per tick, loads a new frame at
// a character boundary if allowed, and holds the break condition.
// Assumes frame and frame_bits are valid whenever hold_full is high.
module sertx_shifter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               tick,
    input  logic               en,
    input  logic               brk,
    input  logic               flow_en,
    input  logic               cts,
    input  logic               hold_full,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   frame_bits,
    output logic               take,
    output logic               active,
    output logic               mid_frame,
    output logic               line
);
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               brk_line;

    assign mid_frame = active && (cnt != '0);
    assign take = tick && !soft_rst && !mid_frame && !brk && !brk_line &&
                  hold_full && en && (!flow_en || cts);

    // Shifts bits out on each tick and decides what happens at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            line     <= 1'b1;
            active   <= 1'b0;
            cnt      <= '0;
            shreg    <= '1;
            brk_line <= 1'b0;
        end else if (tick) begin
            if (mid_frame) begin
                line  <= shreg[0];
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                cnt   <= cnt - CNT_W'(1);
            end else begin
                active <= 1'b0;
                if (brk) begin
                    line     <= 1'b0;
                    brk_line <= 1'b1;
                end else if (brk_line) begin
                    line     <= 1'b1;
                    brk_line <= 1'b0;
                end else if (take) begin
                    line   <= frame[0];
                    shreg  <= {1'b1, frame[FRAME_W-1:1]};
                    cnt    <= frame_bits - CNT_W'(1);
                    active <= 1'b1;
                end else begin
                    line <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Framed serial transmitter: holding register, framer, shifter and command
// control. Assumes bit_tick is a one-cycle pulse from an external divider.
module sertx_top #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_stop2,
    input  logic              cfg_flow_en,
    input  logic              cts,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    output logic              tx_line,
    output logic              ready,
    output logic              empty
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               soft_rst;
    logic               en_q;
    logic               brk_q;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               take;
    logic               active;
    logic               mid_frame;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_bits;

    sertx_cmdctl u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .soft_rst(soft_rst), .en_q(en_q), .brk_q(brk_q)
    );

    sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .en(en_q),
        .wr_en(wr_en), .wr_data(wr_data), .take(take),
        .full(hold_full), .data(hold_data), .ready(ready)
    );

    sertx_framer #(
        .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W),
        .FRAME_W(FRAME_W), .CNT_W(CNT_W)
    ) u_frm (
        .data(hold_data), .len_sel(cfg_len), .par_sel(cfg_par),
        .stop2(cfg_stop2), .frame(frame), .frame_bits(frame_bits)
    );

    sertx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shf (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(bit_tick),
        .en(en_q), .brk(brk_q), .flow_en(cfg_flow_en), .cts(cts),
        .hold_full(hold_full), .frame(frame), .frame_bits(frame_bits),
        .take(take), .active(active), .mid_frame(mid_frame), .line(tx_line)
    );

    assign empty = !active && !hold_full;
endmodule

// File: rtl/sertx_chk.sv
// Checker for sertx_top, attached by bind. It observes ports plus the break
// flag and the in-frame indication from separate submodules.
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       wr_en,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       cts,
    input logic       cfg_flow_en,
    input logic       tx_line,
    input logic       ready,
    input logic       empty,
    input logic       brk_q,
    input logic       mid_frame
);
    logic rst_cmd;
    assign rst_cmd = cmd_valid && (cmd_op == 3'd3);

    p_line_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !rst_cmd) |=> $stable(tx_line));

    p_reset_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (tx_line && !ready && empty));

    p_write_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ready && !rst_cmd) |=> (!ready && !empty));

    p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !mid_frame && cfg_flow_en && !cts && !brk_q && !rst_cmd) |=> tx_line);

    p_break_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !mid_frame && brk_q && !rst_cmd) |=> !tx_line);
endmodule

bind sertx_top sertx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cts(cts),
    .cfg_flow_en(cfg_flow_en), .tx_line(tx_line), .ready(ready),
    .empty(empty), .brk_q(brk_q), .mid_frame(mid_frame)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_flow_en = 1'b0;
    logic       cts = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic       tx_line, ready, empty;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R6 R9 reset";

    always #4 clk = ~clk;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .cfg_flow_en(cfg_flow_en), .cts(cts),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .tx_line(tx_line),
        .ready(ready), .empty(empty)
    );

    // Behavioural reference model
    bit       m_line = 1'b1;
    bit       m_act = 1'b0, m_hv = 1'b0, m_en = 1'b0, m_brk = 1'b0, m_bl = 1'b0;
    bit [7:0] m_hd = '0;
    bit       m_bits[$];

    always @(posedge clk) begin
        bit o_en, o_hv;
        int n, ones;
        if (!rst_n || (cmd_valid && cmd_op == 3'd3)) begin
            m_line = 1'b1; m_act = 1'b0; m_bits.delete();
            m_hv = 1'b0; m_en = 1'b0; m_brk = 1'b0; m_bl = 1'b0;
        end else begin
            o_en = m_en; o_hv = m_hv;
            if (bit_tick) begin
                if (m_act && m_bits.size() > 0) begin
                    m_line = m_bits.pop_front();
                end else begin
                    m_act = 1'b0;
                    if (m_brk) begin
                        m_line = 1'b0; m_bl = 1'b1;
                    end else if (m_bl) begin
                        m_line = 1'b1; m_bl = 1'b0;
                    end else if (m_hv && m_en && (!cfg_flow_en || cts)) begin
                        n = 5 + int'(cfg_len);
                        ones = 0;
                        m_bits.delete();
                        m_bits.push_back(1'b0);
                        for (int k = 0; k < n; k++) begin
                            m_bits.push_back(m_hd[k]);
                            ones += int'(m_hd[k]);
                        end
                        if (cfg_par == 2'd1) m_bits.push_back(bit'(ones % 2));
                        else if (cfg_par == 2'd2) m_bits.push_back(bit'(1 - ones % 2));
                        m_bits.push_back(1'b1);
                        if (cfg_stop2) m_bits.push_back(1'b1);
                        m_line = m_bits.pop_front();
                        m_act = 1'b1;
                        m_hv = 1'b0;
                    end else begin
                        m_line = 1'b1;
                    end
                end
            end
            if (wr_en && o_en && !o_hv) begin
                m_hv = 1'b1; m_hd = wr_data;
            end
            if (cmd_valid) begin
                case (cmd_op)
                    3'd1: m_en = 1'b1;
                    3'd2: m_en = 1'b0;
                    3'd4: m_brk = 1'b1;
                    3'd5: m_brk = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (tx_line !== m_line || ready !== (m_en && !m_hv) ||
                empty !== (!m_act && !m_hv)) begin
                fails++;
                $display("FAIL %s: line/ready/empty got %0b%0b%0b exp %0b%0b%0b",
                         phase, tx_line, ready, empty,
                         m_line, m_en && !m_hv, !m_act && !m_hv);
            end
        end
    end

    // Bit-rate pulse every fourth cycle
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] op);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = '0;
    endtask

    task automatic poke(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        while (!ready) @(negedge clk);
        poke(d);
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b exp %0b", tag, got, exp);
        end
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        expect_bit("R6 reset line mark", tx_line, 1'b1);
        expect_bit("R5 reset ready low", ready, 1'b0);
        expect_bit("R6 reset empty high", empty, 1'b1);

        phase = "R5 write while disabled";
        poke(8'h11);
        cyc(8);
        expect_bit("R5 disabled write ignored", empty, 1'b1);
        cmd(3'd1);

        phase = "R1 R4 R6 len8";
        put(8'hA5); cyc(60);
        phase = "R1 len5";
        cfg_len = 2'd0; put(8'hF3); cyc(50);
        phase = "R2 even";
        cfg_len = 2'd3; cfg_par = 2'd1; put(8'h07); cyc(60);
        phase = "R2 odd";
        cfg_par = 2'd2; put(8'h07); cyc(60);
        phase = "R2 code3 none";
        cfg_par = 2'd3; put(8'h81); cyc(60);
        phase = "R3 two stops";
        cfg_par = 2'd0; cfg_stop2 = 1'b1; put(8'h3C); cyc(60);
        cfg_stop2 = 1'b0;

        phase = "R7 back to back";
        put(8'h55); put(8'hAA); put(8'h0F); cyc(150);
        phase = "R5 write when full";
        put(8'h01); poke(8'h02); put(8'h03); cyc(120);

        phase = "R8 disable";
        put(8'h81); cyc(10); put(8'h7E); cmd(3'd2);
        cyc(100);
        poke(8'h44);
        cyc(4);
        expect_bit("R8 held char not sent while disabled", tx_line, 1'b1);
        cmd(3'd1); cyc(100);

        phase = "R9 reset mid frame";
        put(8'hC3); cyc(14); put(8'h96); cmd(3'd3);
        expect_bit("R9 line mark after reset", tx_line, 1'b1);
        expect_bit("R9 empty after reset", empty, 1'b1);
        cyc(20); cmd(3'd1); put(8'h5A); cyc(80);

        phase = "R10 flow control";
        cfg_flow_en = 1'b1; cts = 1'b0;
        put(8'h66); cyc(40);
        expect_bit("R10 no start without cts", tx_line, 1'b1);
        cts = 1'b1; cyc(10); cts = 1'b0; cyc(60);
        put(8'h99); cyc(40); cts = 1'b1; cyc(60);

        phase = "R11 break";
        cts = 1'b0; cmd(3'd4); cyc(12);
        expect_bit("R11 break low ignoring cts", tx_line, 1'b0);
        put(8'h12); cyc(20);
        phase = "R12 break release";
        cts = 1'b1; cmd(3'd5); cyc(80);
        phase = "R11 break mid frame";
        put(8'h34); cyc(8); cmd(3'd4); cyc(60);
        phase = "R12 release idle";
        cmd(3'd5); cyc(40);

        finish_run();
    end
endmodule